// File: doc/BRIEF.md
# Oscillator Stop Integrity Flag

This block keeps the sticky "timekeeping not trustworthy" status bit of a real-time clock. It runs on a fast system clock and watches a slow square wave derived from the 32.768 kHz crystal oscillator. The slow wave is synchronized into the system domain, and its rising edges are timed with a gap counter. If too many system cycles pass without an edge, the oscillator is treated as stopped and the flag is set. The flag then stays set until the host clears it.

A host clear is accepted only while the oscillator is judged to be running. The block declares "running" only after a run of consecutive edges in which each edge arrives within the timeout window. This keeps a clear from being accepted during power-up or during a shaky restart. Reset forces the flag high, and the start-up interval counts as stopped.

The flag is placed in the top bit of the seconds register image, directly above the seven BCD seconds bits. Neighbouring logic decodes it at that position.

Top module: `osc_integrity_flag`

## Requirements
- R1: After reset the flag is 1, `osc_running` is 0, and `sec_reg[7]` reads 1.
- R2: `sec_reg[7]` carries the flag (1 = integrity not guaranteed, 0 = guaranteed). `sec_reg[6:0]` carries `sec_bcd` unchanged.
- R3: While `osc_running` is 1, a one-cycle `clr_req` clears the flag at that clock edge, so the flag reads 0 in the following cycle.
- R4: While `osc_running` is 0, `clr_req` is ignored and the flag stays 1.
- R5: `osc_running` rises only after GOOD_EDGES consecutive rising edges of `osc_in`, each arriving within TIMEOUT system cycles of the previous one. An input whose period is longer than the window never becomes running.
- R6: When TIMEOUT system cycles pass with no rising edge, `osc_running` falls. The flag is then set one cycle later. Nothing happens earlier while edges keep arriving within the window.
- R7: Once set, the flag stays 1 after the oscillator restarts and becomes running, until a host clear is accepted.
- R8: If a stop and a clear request coincide, the set wins: holding `clr_req` high across a stop still leaves the flag at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_in | input | 1 | Slow oscillator-derived activity signal, asynchronous |
| clr_req | input | 1 | Host request to clear the flag |
| sec_bcd | input | 7 | Current seconds value in BCD |
| sec_reg | output | 8 | Seconds register image: flag in bit 7, BCD seconds below |
| osc_running | output | 1 | Oscillator judged running |
| integrity_lost | output | 1 | Sticky flag, 1 = integrity not guaranteed |

## Verification
A rising input edge reaches the edge detector after the synchronizer stages, so the start and stop decisions are checked with waits that lie well past their due cycles. These waits are also short enough that a premature decision shows up: the bench checks that `osc_running` is still 1 forty cycles into a stop with a 64-cycle window. A clear accepted on an edge is due in the very next cycle, and the bench samples it there on the falling edge. The register image is combinational from the flag and `sec_bcd`, so it is sampled in the same cycle as the flag.

// File: rtl/osf_pkg.sv
package osf_pkg;

    typedef enum logic {
        OSC_STOPPED = 1'b0,
        OSC_RUNNING = 1'b1
    } osc_state_e;

    typedef struct packed {
        logic level;
        logic rise;
    } osc_sample_t;

    function automatic int unsigned cnt_width(input int unsigned maxv);
        return (maxv < 2) ? 1 : $clog2(maxv + 1);
    endfunction

endpackage

// File: rtl/osf_edge_sync.sv
module osf_edge_sync
    import osf_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        osc_in,
    output osc_sample_t sample
);
    // Synchronizer chain plus one extra stage for edge detection.
    logic [SYNC_STAGES:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= {pipe[SYNC_STAGES-1:0], osc_in};
    end

    always_comb begin
        sample.level = pipe[SYNC_STAGES-1];
        sample.rise  = pipe[SYNC_STAGES-1] & ~pipe[SYNC_STAGES];
    end
endmodule

// File: rtl/osf_activity.sv
module osf_activity
    import osf_pkg::*;
#(
    parameter int unsigned TIMEOUT    = 8192,
    parameter int unsigned GOOD_EDGES = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  osc_sample_t sample,
    output osc_state_e  state
);
    localparam int unsigned GAP_W  = cnt_width(TIMEOUT);
    localparam int unsigned GOOD_W = cnt_width(GOOD_EDGES);
    localparam logic [GAP_W-1:0]  GAP_MAX  = GAP_W'(TIMEOUT);
    localparam logic [GOOD_W-1:0] GOOD_MAX = GOOD_W'(GOOD_EDGES);

    logic [GAP_W-1:0]  gap_q,  gap_d;
    logic [GOOD_W-1:0] good_q, good_d;
    osc_state_e        st_q,   st_d;
    logic              late;

    assign late = (gap_q == GAP_MAX);

    always_comb begin
        gap_d  = gap_q;
        good_d = good_q;
        st_d   = st_q;
        if (sample.rise) begin
            // Edge inside the window (up to and including TIMEOUT).
            gap_d  = '0;
            good_d = (good_q == GOOD_MAX) ? good_q : good_q + 1'b1;
            if (good_d == GOOD_MAX) st_d = OSC_RUNNING;
        end else if (late) begin
            // Window expired: stopped, qualification restarts.
            good_d = '0;
            st_d   = OSC_STOPPED;
        end else begin
            gap_d = gap_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q  <= '0;
            good_q <= '0;
            st_q   <= OSC_STOPPED;
        end else begin
            gap_q  <= gap_d;
            good_q <= good_d;
            st_q   <= st_d;
        end
    end

    assign state = st_q;
endmodule

// File: rtl/osf_flag.sv
module osf_flag
    import osf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  osc_state_e state,
    input  logic       clr_req,
    output logic       flag
);
    // Set has priority over clear; a clear counts only while running.
    always_ff @(posedge clk) begin
        if (rst)                        flag <= 1'b1;
        else if (state != OSC_RUNNING)  flag <= 1'b1;
        else if (clr_req)               flag <= 1'b0;
    end
endmodule

// File: rtl/osc_integrity_flag.sv
module osc_integrity_flag
    import osf_pkg::*;
#(
    parameter int unsigned TIMEOUT     = 8192,
    parameter int unsigned GOOD_EDGES  = 8,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned SEC_W       = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             osc_in,
    input  logic             clr_req,
    input  logic [SEC_W-1:0] sec_bcd,
    output logic [SEC_W:0]   sec_reg,
    output logic             osc_running,
    output logic             integrity_lost
);
    osc_sample_t sample;
    osc_state_e  state;

    osf_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .osc_in (osc_in),
        .sample (sample)
    );

    osf_activity #(.TIMEOUT(TIMEOUT), .GOOD_EDGES(GOOD_EDGES)) u_act (
        .clk    (clk),
        .rst    (rst),
        .sample (sample),
        .state  (state)
    );

    osf_flag u_flag (
        .clk     (clk),
        .rst     (rst),
        .state   (state),
        .clr_req (clr_req),
        .flag    (integrity_lost)
    );

    assign osc_running = (state == OSC_RUNNING);
    assign sec_reg     = {integrity_lost, sec_bcd};
endmodule

// File: rtl/osc_integrity_flag_chk.sv
module osc_integrity_flag_chk (
    input logic clk,
    input logic rst,
    input logic clr_req,
    input logic osc_running,
    input logic integrity_lost
);
    // R1: flag still set in the first cycle after reset
    p_reset_set_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> integrity_lost);

    // R3: accepted clear is visible next cycle
    p_clear_taken_r3: assert property (@(posedge clk) disable iff (rst)
        (osc_running && clr_req) |=> !integrity_lost);

    // R4 / R6: not running forces the flag set
    p_stopped_sets_r4: assert property (@(posedge clk) disable iff (rst)
        !osc_running |=> integrity_lost);

    // R7: no clear request, flag stays set
    p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (integrity_lost && !clr_req) |=> integrity_lost);

    // R8: a fall of the flag needs a clear while running
    p_fall_cause_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(integrity_lost) |-> ($past(clr_req) && $past(osc_running)));
endmodule

bind osc_integrity_flag osc_integrity_flag_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .clr_req        (clr_req),
    .osc_running    (osc_running),
    .integrity_lost (integrity_lost)
);

// File: tb/osc_integrity_flag_test.sv
module osc_integrity_flag_test;
    localparam int unsigned TO = 64;
    localparam int unsigned GE = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       osc_in = 1'b0;
    logic       clr_req = 1'b0;
    logic [6:0] sec_bcd = 7'h59;
    logic [7:0] sec_reg;
    logic       osc_running;
    logic       integrity_lost;

    logic osc_en = 1'b0;
    int   osc_half = 10;
    int   ph = 0;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    always #4 clk = ~clk;

    osc_integrity_flag #(.TIMEOUT(TO), .GOOD_EDGES(GE)) uut (
        .clk            (clk),
        .rst            (rst),
        .osc_in         (osc_in),
        .clr_req        (clr_req),
        .sec_bcd        (sec_bcd),
        .sec_reg        (sec_reg),
        .osc_running    (osc_running),
        .integrity_lost (integrity_lost)
    );

    // Slow oscillator model, stepped on falling edges.
    always @(negedge clk) begin
        if (osc_en) begin
            if (ph >= osc_half - 1) begin
                ph     <= 0;
                osc_in <= ~osc_in;
            end else begin
                ph <= ph + 1;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_clear();
        clr_req = 1'b1;
        cyc(1);
        clr_req = 1'b0;
    endtask

    task automatic t_reset();
        cyc(3);
        rst = 1'b0;
        cyc(1);
        chk("R1 flag", integrity_lost, 1);
        chk("R1 running", osc_running, 0);
        chk("R2 image", sec_reg, 8'hD9);
    endtask

    task automatic t_clear_stopped();
        pulse_clear();
        chk("R4 clear while stopped", integrity_lost, 1);
        cyc(5);
        chk("R4 flag held", integrity_lost, 1);
    endtask

    task automatic t_startup();
        osc_en = 1'b1;
        cyc(30);
        chk("R5 not running after few edges", osc_running, 0);
        pulse_clear();
        chk("R4 clear during startup", integrity_lost, 1);
        cyc(150);
        chk("R5 running", osc_running, 1);
        chk("R7 flag kept after start", integrity_lost, 1);
    endtask

    task automatic t_clear_running();
        sec_bcd = 7'h37;
        pulse_clear();
        chk("R3 cleared", integrity_lost, 0);
        chk("R2 image after clear", sec_reg, 8'h37);
        cyc(200);
        chk("R3 stays clear while running", integrity_lost, 0);
    endtask

    task automatic t_stop_restart();
        osc_en = 1'b0;
        cyc(40);
        chk("R6 not premature", osc_running, 1);
        chk("R6 flag not premature", integrity_lost, 0);
        cyc(60);
        chk("R6 stopped", osc_running, 0);
        chk("R6 flag set", integrity_lost, 1);
        chk("R2 image on stop", sec_reg, 8'hB7);
        osc_en = 1'b1;
        cyc(150);
        chk("R5 running again", osc_running, 1);
        chk("R7 sticky after restart", integrity_lost, 1);
        pulse_clear();
        chk("R3 cleared after restart", integrity_lost, 0);
    endtask

    task automatic t_slow_osc();
        osc_en = 1'b0;
        cyc(100);
        osc_half = 80;
        osc_en = 1'b1;
        cyc(700);
        chk("R5 slow input never runs", osc_running, 0);
        pulse_clear();
        chk("R4 clear on slow input", integrity_lost, 1);
        osc_en = 1'b0;
        osc_half = 10;
        cyc(5);
        osc_en = 1'b1;
        cyc(150);
        chk("R5 fast again runs", osc_running, 1);
        pulse_clear();
        chk("R3 clear before collision", integrity_lost, 0);
    endtask

    task automatic t_collision();
        clr_req = 1'b1;
        osc_en = 1'b0;
        cyc(100);
        chk("R8 set wins over held clear", integrity_lost, 1);
        chk("R8 stopped", osc_running, 0);
        clr_req = 1'b0;
    endtask

    initial begin
        t_reset();
        t_clear_stopped();
        t_startup();
        t_clear_running();
        t_stop_restart();
        t_slow_osc();
        t_collision();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule